// File: doc/BRIEF.md
# DSP Load Address Generator

This block works out, for a single load, the byte address to read and the value the pointer register should take afterwards. A three-bit mode input picks one of eight ways to form that address. Two modes compute the address without touching the pointer. The other six read at an absolute address or at the pointer itself and then write a new pointer value. The pointer update can be a plain increment, a bit-reversed walk for FFT-style buffers, or a wrap inside a circular buffer.

The load unit of a core drives the register operands and the mode. It uses `eff_addr` to access memory and writes `ptr_nxt` back to the pointer register whenever `ptr_wr` is high. The block does no memory access and detects no faults. A parameter selects whether the outputs come straight from the logic or through one register stage.

Top module: `dsp_ldaddr_gen`

## Requirements
- R1: Mode 0 (offset) gives `eff_addr = ptr_in + imm`, with `imm` read as two's complement. It drives `ptr_nxt = ptr_in` and `ptr_wr = 0`.
- R2: Mode 1 (scaled index) gives `eff_addr = (idx_in << shamt) + abs_in`, with `ptr_nxt = ptr_in` and `ptr_wr = 0`.
- R3: Mode 2 (absolute) drives `abs_in` onto both `eff_addr` and `ptr_nxt`, with `ptr_wr = 1`.
- R4: Mode 3 (step by register) and mode 5 (step by immediate) give `eff_addr = ptr_in` and `ptr_wr = 1`. Mode 3 drives `ptr_nxt = ptr_in + mod_in` and mode 5 drives `ptr_nxt = ptr_in + imm`.
- R5: Mode 4 (bit-reversed) forms `eff_addr` from `ptr_in[31:16]` in the upper half and the mirror image of `ptr_in[15:0]` in the lower half, so bit k moves to bit 15-k. It drives `ptr_nxt = ptr_in + mod_in` and `ptr_wr = 1`. With a step of 0x2000 from a 64 KiB-aligned pointer, the addresses fall at offsets 0, 4, 2, 6.
- R6: Mode 6 (circular, immediate step) gives `eff_addr = ptr_in` and `ptr_wr = 1`. With L = `mod_in[16:0]`, it drives `ptr_nxt = cstart + ((ptr_in - cstart + imm) mod L)`. The result stays in [0, L) even when `imm` is negative. With L=6 and a step of 2, the offsets run 0, 2, 4, 0.
- R7: Mode 7 (circular, register step) works like mode 6, except that the step is the signed 7-bit field `mod_in[23:17]` multiplied by the access size. The size is 4 bytes when `size4 = 1` and 2 bytes otherwise, and `mod_in[31:24]` is ignored. With step field 1, size 4 and L=8, the offsets run 0, 4, 0, 4.
- R8: `ptr_wr` is 1 in modes 2 to 7 and 0 in modes 0 and 1.
- R9: With `REG_OUT = 1`, every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs read 0. With `REG_OUT = 0`, the outputs follow the inputs with no clock.
- R10: All additions and shifts are 32-bit and wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only when REG_OUT = 1 |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| mode | input | 3 | Addressing mode, 0 to 7 |
| size4 | input | 1 | Access size: 1 means 4 bytes, 0 means 2 bytes |
| ptr_in | input | 32 | Base or pointer register value |
| idx_in | input | 32 | Index register value |
| imm | input | 32 | Immediate offset or step, two's complement |
| shamt | input | 5 | Left shift applied to the index |
| abs_in | input | 32 | Absolute address constant |
| mod_in | input | 32 | Modifier register: step, or packed length and step |
| cstart | input | 32 | Start address of the circular buffer |
| eff_addr | output | 32 | Address of the load |
| ptr_nxt | output | 32 | Pointer value after the load |
| ptr_wr | output | 1 | Pointer write enable |

## Verification
Each output is a pure function of a single set of inputs, so a wrong internal value appears on `eff_addr` or `ptr_nxt` for exactly the vector that triggers it. It appears in the same cycle in the unregistered variant and one edge later in the registered one. The bench therefore compares every vector against a model that computes circular wrap with modulo arithmetic and builds bit reversal from a weighted sum, not from the RTL's structure. Wrap errors near the buffer ends and sign errors on negative steps show up as a pointer outside [cstart, cstart+L). The sweeps over length, offset and step reach all of those positions.

// File: rtl/dsp_ldaddr_gen.sv
module dsp_ldaddr_gen #(
  parameter bit REG_OUT = 1'b1,
  parameter int AW      = 32,
  parameter int BREV_W  = 16,
  parameter int LEN_W   = 17,
  parameter int CINC_W  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          size4,
  input  logic [AW-1:0] ptr_in,
  input  logic [AW-1:0] idx_in,
  input  logic [AW-1:0] imm,
  input  logic [4:0]    shamt,
  input  logic [AW-1:0] abs_in,
  input  logic [AW-1:0] mod_in,
  input  logic [AW-1:0] cstart,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_nxt,
  output logic          ptr_wr
);
  localparam logic [2:0] M_OFS = 3'd0, M_SIDX = 3'd1, M_ABS = 3'd2, M_STPR = 3'd3,
                         M_BREV = 3'd4, M_STPI = 3'd5, M_CIRI = 3'd6, M_CIRR = 3'd7;
  localparam int INC_LO = LEN_W;
  localparam int INC_HI = LEN_W + CINC_W - 1;

  logic [BREV_W-1:0] mirror;
  always_comb
    for (int k = 0; k < BREV_W; k++) mirror[k] = ptr_in[BREV_W-1-k];

  wire [AW-1:0] clen   = {{(AW-LEN_W){1'b0}}, mod_in[LEN_W-1:0]};
  wire [AW-1:0] rstep  = {{(AW-CINC_W){mod_in[INC_HI]}}, mod_in[INC_HI:INC_LO]};
  wire [AW-1:0] rscale = size4 ? (rstep << 2) : (rstep << 1);
  wire [AW-1:0] cstep  = (mode == M_CIRR) ? rscale : imm;
  wire [AW-1:0] csum   = (ptr_in - cstart) + cstep;

  logic [AW-1:0] cwrap;
  always_comb begin
    if (csum[AW-1])        cwrap = csum + clen;
    else if (csum >= clen) cwrap = csum - clen;
    else                   cwrap = csum;
  end

  logic [AW-1:0] ea_c, pn_c;
  logic          we_c;
  always_comb begin
    ea_c = ptr_in;
    pn_c = ptr_in;
    we_c = 1'b1;
    unique case (mode)
      M_OFS:  begin ea_c = ptr_in + imm; we_c = 1'b0; end
      M_SIDX: begin ea_c = (idx_in << shamt) + abs_in; we_c = 1'b0; end
      M_ABS:  begin ea_c = abs_in; pn_c = abs_in; end
      M_STPR: pn_c = ptr_in + mod_in;
      M_BREV: begin ea_c = {ptr_in[AW-1:BREV_W], mirror}; pn_c = ptr_in + mod_in; end
      M_STPI: pn_c = ptr_in + imm;
      default: pn_c = cstart + cwrap;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          eff_addr <= '0;
          ptr_nxt  <= '0;
          ptr_wr   <= 1'b0;
          primed   <= 1'b0;
        end else begin
          eff_addr <= ea_c;
          ptr_nxt  <= pn_c;
          ptr_wr   <= we_c;
          primed   <= 1'b1;
        end
      end

      p_wr_by_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (ptr_wr == ($past(mode) >= M_ABS)));
      p_keep_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode) <= M_SIDX) |-> (ptr_nxt == $past(ptr_in)));
      p_abs_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode) == M_ABS) |-> (eff_addr == ptr_nxt));
      p_brev_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode) == M_BREV) |->
          (eff_addr[AW-1:BREV_W] == $past(ptr_in[AW-1:BREV_W])));
      p_circ_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode) >= M_CIRI && $past(mod_in[LEN_W-1:0]) != '0 &&
         $past(ptr_in - cstart) < $past(clen) &&
         ($past(cstep) < $past(clen) || (-$past(cstep)) < $past(clen)))
        |-> ((ptr_nxt - $past(cstart)) < $past(clen)));
    end else begin : g_comb
      assign eff_addr = ea_c;
      assign ptr_nxt  = pn_c;
      assign ptr_wr   = we_c;
    end
  endgenerate
endmodule

// File: tb/dsp_ldaddr_gen_bench.sv
module dsp_ldaddr_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic size4 = 1'b0;
  logic [31:0] ptr_in = '0, idx_in = '0, imm = '0, abs_in = '0, mod_in = '0, cstart = '0;
  logic [4:0] shamt = '0;
  logic [31:0] ea_r, pn_r, ea_c, pn_c;
  logic we_r, we_c;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dsp_ldaddr_gen #(.REG_OUT(1'b1)) u_dsp_ldaddr_gen (
    .clk, .rst_n, .mode, .size4, .ptr_in, .idx_in, .imm, .shamt, .abs_in, .mod_in, .cstart,
    .eff_addr(ea_r), .ptr_nxt(pn_r), .ptr_wr(we_r));
  dsp_ldaddr_gen #(.REG_OUT(1'b0)) u_comb (
    .clk, .rst_n, .mode, .size4, .ptr_in, .idx_in, .imm, .shamt, .abs_in, .mod_in, .cstart,
    .eff_addr(ea_c), .ptr_nxt(pn_c), .ptr_wr(we_c));

  logic [31:0] x_ea, x_pn, p_ea, p_pn;
  logic x_we, p_we, p_valid = 1'b0;
  string p_tag;

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1 R8";  3'd1: return "R2 R8";  3'd2: return "R3 R8";
      3'd3: return "R4 R8";  3'd4: return "R5 R8";  3'd5: return "R4 R8";
      3'd6: return "R6 R8";  default: return "R7 R8";
    endcase
  endfunction

  task automatic model();
    longint off, len, st, r;
    logic [31:0] lo;
    x_ea = ptr_in; x_pn = ptr_in; x_we = (mode >= 3'd2);
    len = longint'(mod_in[16:0]);
    case (mode)
      3'd0: x_ea = ptr_in + imm;
      3'd1: x_ea = idx_in * (32'd1 << shamt) + abs_in;
      3'd2: begin x_ea = abs_in; x_pn = abs_in; end
      3'd3: x_pn = ptr_in + mod_in;
      3'd4: begin
        lo = 0;
        for (int b = 0; b < 16; b++) lo = lo + (((ptr_in >> b) & 32'd1) * (32'd1 << (15 - b)));
        x_ea = (ptr_in & 32'hFFFF_0000) + lo;
        x_pn = ptr_in + mod_in;
      end
      3'd5: x_pn = ptr_in + imm;
      default: begin
        off = longint'($signed(ptr_in - cstart));
        if (mode == 3'd6) st = longint'($signed(imm));
        else st = longint'($signed(mod_in[23:17])) * (size4 ? 4 : 2);
        r = ((off + st) % len + len) % len;
        x_pn = cstart + 32'(r);
      end
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] ae, ap, input logic aw,
                     input logic [31:0] ee, ep, input logic ew);
    checks++;
    if (ae !== ee || ap !== ep || aw !== ew) begin
      errors++;
      $display("FAIL %s: got ea=%h ptr=%h wr=%b, expected ea=%h ptr=%h wr=%b",
               tag, ae, ap, aw, ee, ep, ew);
    end
  endtask

  // One vector per cycle: check previous registered result, then apply and check combinational.
  task automatic step();
    @(negedge clk);
    if (p_valid) chk({"R9 ", p_tag}, ea_r, pn_r, we_r, p_ea, p_pn, p_we);
  endtask

  task automatic apply();
    #1;
    model();
    chk(tag_of(mode), ea_c, pn_c, we_c, x_ea, x_pn, x_we);
    p_ea = x_ea; p_pn = x_pn; p_we = x_we; p_tag = tag_of(mode); p_valid = 1'b1;
  endtask

  task automatic ofs_expect(input string tag, input logic [31:0] got, want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    chk("R9 reset", ea_r, pn_r, we_r, 32'd0, 32'd0, 1'b0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R8: random sweep of the non-circular modes
    for (int m = 0; m < 6; m++)
      for (int t = 0; t < 600; t++) begin
        step();
        mode = 3'(m); size4 = 1'($urandom); ptr_in = $urandom; idx_in = $urandom;
        imm = $urandom; shamt = 5'($urandom); abs_in = $urandom; mod_in = $urandom;
        cstart = $urandom;
        apply();
      end

    // R10: wrap past 2^32
    step(); mode = 3'd0; ptr_in = 32'hFFFF_FFF0; imm = 32'h20; apply();
    ofs_expect("R10 offset wrap", ea_c, 32'h0000_0010);
    step(); mode = 3'd1; idx_in = 32'hC000_0001; shamt = 5'd2; abs_in = 32'h8; apply();
    ofs_expect("R10 shift wrap", ea_c, 32'h0000_000C);

    // R5: bit-reversed walk with step 0x2000 from an aligned pointer
    p = 32'h0005_0000;
    for (int i = 0; i < 4; i++) begin
      step(); mode = 3'd4; ptr_in = p; mod_in = 32'h2000; apply();
      ofs_expect("R5 brev sequence", ea_c - 32'h0005_0000,
                 (i == 0) ? 32'd0 : (i == 1) ? 32'd4 : (i == 2) ? 32'd2 : 32'd6);
      p = pn_c;
    end
    // R5: sweep of low halves
    for (int v = 0; v < 4096; v++) begin
      step(); mode = 3'd4; ptr_in = {16'($urandom), 16'(v * 16 + (v >> 8))}; mod_in = $urandom;
      apply();
    end

    // R6: circular with immediate step, length 6, step 2
    p = 32'h0000_1000;
    for (int i = 0; i < 4; i++) begin
      step(); mode = 3'd6; ptr_in = p; cstart = 32'h1000; mod_in = 32'd6; imm = 32'd2; apply();
      ofs_expect("R6 circ sequence", ea_c - 32'h1000, (i == 3) ? 32'd0 : 32'(2 * i));
      p = pn_c;
    end
    // R6: sweep length, offset and signed step
    for (int len = 1; len <= 12; len++)
      for (int o = 0; o < len; o++)
        for (int s = -(len - 1); s < len; s++) begin
          step(); mode = 3'd6; cstart = 32'h8000_0000 - 32'(len); ptr_in = cstart + 32'(o);
          mod_in = {15'($urandom), 17'(len)}; imm = 32'(s); apply();
        end

    // R7: circular with packed register step, step field 1, size 4, length 8
    p = 32'h0002_0000;
    for (int i = 0; i < 4; i++) begin
      step(); mode = 3'd7; size4 = 1'b1; ptr_in = p; cstart = 32'h0002_0000;
      mod_in = (32'd1 << 17) | 32'd8; apply();
      ofs_expect("R7 circ reg sequence", ea_c - 32'h0002_0000, (i % 2 == 1) ? 32'd4 : 32'd0);
      p = pn_c;
    end
    // R7: sweep with ignored upper modifier bits
    for (int sz = 0; sz < 2; sz++)
      for (int len = 1; len <= 16; len++)
        for (int o = 0; o < len; o++)
          for (int s = -8; s < 8; s++)
            if ((s < 0 ? -s : s) * (sz ? 4 : 2) < len) begin
              step(); mode = 3'd7; size4 = 1'(sz); cstart = $urandom;
              ptr_in = cstart + 32'(o);
              mod_in = {8'($urandom), 7'(s), 17'(len)}; apply();
            end

    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule